// File: doc/BRIEF.md
# Power and Reset Control Register

This block holds one 8-bit control word for a video decoder core and turns its fields into the core's power-state and reset controls. Software writes the word through a single-cycle strobe. The block also takes two asynchronous board pins: a power-down request and a timing-reacquire request. Both pins are synchronized before the block uses them.

The block produces these outputs:

- a two-bit power-save mode code;
- separate save enables for the internal reference and for the line-locked clock generator;
- the effective power-down level, with a pad-disable that follows it and a main clock enable that is its inverse;
- a one-cycle reacquire pulse;
- a one-cycle soft reset.

A priority bit chooses whether the power-down pin or the power-down register bit governs the core. The reacquire bit and the reset bit clear themselves, so software triggers an action with a single write. When the reset bit fires, it also clears the whole control word.

Top module: `pwr_rst_ctrl`

## Requirements
- R1: After rst_n is deasserted, rd_data, psave_mode_o, ref_save_o, cgen_save_o, pdn_eff_o, pad_dis_o, reacq_pulse_o and soft_rst_o are 0, and clk_en_o is 1.
- R2: Bits [1:0] of a write give the mode code on psave_mode_o in the cycle after the write. The codes are 0 full operation, 1 composite input only, 2 digital only, 3 power save. The same value reads back in rd_data[1:0].
- R3: Bit 2 of a write drives ref_save_o and bit 3 drives cgen_save_o, from the cycle after the write.
- R4: When bit 5 (priority) is 1, pdn_eff_o equals bit 4 (power-down bit), and the power-down pin has no effect.
- R5: When bit 5 is 0, pdn_eff_o follows the power-down pin two clock edges after the pin changes, and bit 4 has no effect.
- R6: pad_dis_o equals pdn_eff_o, and clk_en_o is its inverse.
- R7: A write with bit 6 set makes reacq_pulse_o high for exactly the one cycle after the write. The bit then clears itself.
- R8: A rising edge on the reacquire pin makes reacq_pulse_o high for one cycle, two clock edges after the pin rises. A pin held high gives no further pulse.
- R9: A write with bit 7 set makes soft_rst_o high for exactly the one cycle after the write. At the next edge all fields become 0, and a write made in that cycle is discarded.
- R10: rd_data returns bits [5:0] as stored, and bits [7:6] always read 0.
- R11: With no write and no soft reset, rd_data holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register readback, with the self-clearing bits reading 0 |
| pdn_pin | input | 1 | Asynchronous power-down pin, active high |
| reacq_pin | input | 1 | Asynchronous reacquire request pin, active high |
| psave_mode_o | output | 2 | Power-save mode code |
| ref_save_o | output | 1 | Reference power-save enable |
| cgen_save_o | output | 1 | Clock generator power-save enable |
| pdn_eff_o | output | 1 | Effective power-down |
| pad_dis_o | output | 1 | Input pad disable |
| clk_en_o | output | 1 | Main clock enable |
| reacq_pulse_o | output | 1 | One-cycle timing reacquire |
| soft_rst_o | output | 1 | One-cycle core and register-interface reset |

## Verification
A stuck self-clearing bit appears as reacq_pulse_o or soft_rst_o staying high into a second cycle. The checks watch for this one cycle after the write. A wrong priority selection, or a missing synchronizer stage, changes pdn_eff_o, pad_dis_o and clk_en_o either at the wrong edge or not at all. The bench samples these outputs at each edge across the pin's two-edge latency. A field that decodes to the wrong bit is visible in rd_data and on the matching output in the cycle after the write.

// File: rtl/pwr_rst_pkg.sv
package pwr_rst_pkg;

   localparam int unsigned CTRL_W = 8;

   typedef enum logic [1:0] {
      PM_FULL      = 2'd0,
      PM_COMPOSITE = 2'd1,
      PM_DIGITAL   = 2'd2,
      PM_SAVE      = 2'd3
   } psave_mode_e;

   // Field layout, most significant bit first.
   typedef struct packed {
      logic        soft_rst;   // bit 7, self-clearing
      logic        reacq;      // bit 6, self-clearing
      logic        pdn_pri;    // bit 5, 1: the register bit governs power-down
      logic        pdn_bit;    // bit 4
      logic        cg_save;    // bit 3
      logic        ref_save;   // bit 2
      psave_mode_e mode;       // bits 1:0
   } ctrl_fields_t;

   localparam logic [CTRL_W-1:0] SELF_CLR_MASK = 8'hC0;

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= 1'b0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/pwr_ctrl_reg.sv
module pwr_ctrl_reg
   import pwr_rst_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   output ctrl_fields_t      fields_o,
   output logic [CTRL_W-1:0] rd_data_o
);

   ctrl_fields_t regq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         regq <= '0;
      end else if (regq.soft_rst) begin
         // A soft reset clears the whole word and discards any write.
         regq <= '0;
      end else if (wr_en) begin
         regq <= ctrl_fields_t'(wr_data);
      end else begin
         regq.reacq <= 1'b0;
      end
   end

   assign fields_o  = regq;
   assign rd_data_o = CTRL_W'(regq) & ~SELF_CLR_MASK;

endmodule

// File: rtl/pwr_pdn_arb.sv
module pwr_pdn_arb (
   input  logic pdn_pri,
   input  logic pdn_bit,
   input  logic pdn_pin_s,
   output logic pdn_eff,
   output logic pad_dis,
   output logic clk_en
);

   always_comb begin
      pdn_eff = pdn_pri ? pdn_bit : pdn_pin_s;
      pad_dis = pdn_eff;
      clk_en  = ~pdn_eff;
   end

endmodule

// File: rtl/pwr_reacq_gen.sv
module pwr_reacq_gen #(
   parameter bit PIN_EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_s,
   input  logic reg_pulse,
   output logic reacq_o
);

   logic pin_req;

   if (PIN_EDGE) begin : g_edge
      logic pin_d;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pin_d <= 1'b0;
         else        pin_d <= pin_s;
      end
      assign pin_req = pin_s & ~pin_d;
   end else begin : g_level
      assign pin_req = pin_s;
   end

   assign reacq_o = reg_pulse | pin_req;

endmodule

// File: rtl/pwr_rst_ctrl.sv
module pwr_rst_ctrl
   import pwr_rst_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          REACQ_EDGE  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   output logic [7:0] rd_data,
   input  logic       pdn_pin,
   input  logic       reacq_pin,
   output logic [1:0] psave_mode_o,
   output logic       ref_save_o,
   output logic       cgen_save_o,
   output logic       pdn_eff_o,
   output logic       pad_dis_o,
   output logic       clk_en_o,
   output logic       reacq_pulse_o,
   output logic       soft_rst_o
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pwr_rst_ctrl: SYNC_STAGES must be at least 2");
   end
   if (CTRL_W != 8) begin : g_bad_width
      $error("pwr_rst_ctrl: control word must be 8 bits");
   end

   ctrl_fields_t fields;
   logic         pdn_s;
   logic         reacq_s;

   pwr_ctrl_reg i_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .fields_o  (fields),
      .rd_data_o (rd_data)
   );

   pwr_sync #(.STAGES(SYNC_STAGES)) i_sync_pdn (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pdn_pin),
      .q     (pdn_s)
   );

   pwr_sync #(.STAGES(SYNC_STAGES)) i_sync_reacq (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (reacq_pin),
      .q     (reacq_s)
   );

   pwr_pdn_arb i_arb (
      .pdn_pri   (fields.pdn_pri),
      .pdn_bit   (fields.pdn_bit),
      .pdn_pin_s (pdn_s),
      .pdn_eff   (pdn_eff_o),
      .pad_dis   (pad_dis_o),
      .clk_en    (clk_en_o)
   );

   pwr_reacq_gen #(.PIN_EDGE(REACQ_EDGE)) i_reacq (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_s     (reacq_s),
      .reg_pulse (fields.reacq),
      .reacq_o   (reacq_pulse_o)
   );

   assign psave_mode_o = fields.mode;
   assign ref_save_o   = fields.ref_save;
   assign cgen_save_o  = fields.cg_save;
   assign soft_rst_o   = fields.soft_rst;

endmodule

// File: rtl/pwr_rst_ctrl_chk.sv
module pwr_rst_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [7:0] wr_data,
   input logic [7:0] rd_data,
   input logic [1:0] psave_mode_o,
   input logic       ref_save_o,
   input logic       cgen_save_o,
   input logic       pdn_eff_o,
   input logic       pad_dis_o,
   input logic       clk_en_o,
   input logic       reacq_pulse_o,
   input logic       soft_rst_o
);

   assert_mode_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !soft_rst_o) |=> (psave_mode_o == $past(wr_data[1:0])));

   assert_save_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !soft_rst_o) |=> (ref_save_o == $past(wr_data[2]) &&
                                  cgen_save_o == $past(wr_data[3])));

   assert_bit_priority_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[5] |-> (pdn_eff_o == rd_data[4]));

   assert_pad_clk_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_dis_o == pdn_eff_o) && (clk_en_o != pdn_eff_o));

   assert_reacq_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[6] && !soft_rst_o) |=> reacq_pulse_o);

   assert_soft_rst_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_o |=> (!soft_rst_o && rd_data == 8'h00));

   assert_selfclr_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[7:6] == 2'b00);

   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !soft_rst_o) |=> $stable(rd_data));

endmodule

bind pwr_rst_ctrl pwr_rst_ctrl_chk i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_en         (wr_en),
   .wr_data       (wr_data),
   .rd_data       (rd_data),
   .psave_mode_o  (psave_mode_o),
   .ref_save_o    (ref_save_o),
   .cgen_save_o   (cgen_save_o),
   .pdn_eff_o     (pdn_eff_o),
   .pad_dis_o     (pad_dis_o),
   .clk_en_o      (clk_en_o),
   .reacq_pulse_o (reacq_pulse_o),
   .soft_rst_o    (soft_rst_o)
);

// File: tb/test_pwr_rst_ctrl.sv
`timescale 1ns/1ps
module test_pwr_rst_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       pdn_pin = 1'b0;
   logic       reacq_pin = 1'b0;
   logic [1:0] psave_mode_o;
   logic       ref_save_o, cgen_save_o, pdn_eff_o, pad_dis_o, clk_en_o;
   logic       reacq_pulse_o, soft_rst_o;

   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   pwr_rst_ctrl i_pwr_rst_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .pdn_pin(pdn_pin), .reacq_pin(reacq_pin),
      .psave_mode_o(psave_mode_o), .ref_save_o(ref_save_o),
      .cgen_save_o(cgen_save_o), .pdn_eff_o(pdn_eff_o),
      .pad_dis_o(pad_dis_o), .clk_en_o(clk_en_o),
      .reacq_pulse_o(reacq_pulse_o), .soft_rst_o(soft_rst_o)
   );

   // {write data, expected rd_data, expected {ref, cg, pdn, pad, clk_en}}
   // Pin inputs are low for the whole table.
   localparam logic [20:0] VEC [8] = '{
      {8'h01, 8'h01, 5'b00001},
      {8'h06, 8'h06, 5'b10001},
      {8'h0B, 8'h0B, 5'b01001},
      {8'h30, 8'h30, 5'b00110},
      {8'h10, 8'h10, 5'b00001},
      {8'h4D, 8'h0D, 5'b11001},
      {8'h2C, 8'h2C, 5'b11001},
      {8'h00, 8'h00, 5'b00001}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [4:0] outs();
      return {ref_save_o, cgen_save_o, pdn_eff_o, pad_dis_o, clk_en_o};
   endfunction

   // Drives a write for one edge and returns at the next negedge.
   task automatic write_reg(input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 rd_data", rd_data, 8'h00);
      check("R1 outs", {psave_mode_o, outs()}, 7'b0000001);
      check("R1 pulses", {reacq_pulse_o, soft_rst_o}, 2'b00);

      // R2 R3 R4 R5 R6 R7 R10 table walk
      foreach (VEC[i]) begin
         write_reg(VEC[i][20:13]);
         check("R10 rd_data", rd_data, VEC[i][12:5]);
         check("R2 mode", psave_mode_o, VEC[i][6:5]);
         check("R3 R6 outs", outs(), VEC[i][4:0]);
         check("R7 pulse", reacq_pulse_o, VEC[i][19]);
         @(negedge clk);
         check("R7 self-clear", reacq_pulse_o, 1'b0);
      end

      // R4: the bit governs while the pin is high
      write_reg(8'h30);
      pdn_pin = 1'b1;
      repeat (4) @(negedge clk);
      check("R4 bit set pin high", pdn_eff_o, 1'b1);
      write_reg(8'h20);
      repeat (2) @(negedge clk);
      check("R4 pin ignored", pdn_eff_o, 1'b0);
      check("R6 clk_en", clk_en_o, 1'b1);
      pdn_pin = 1'b0;
      repeat (3) @(negedge clk);

      // R5: the pin governs, with two-edge latency, and the bit is ignored
      write_reg(8'h10);
      check("R5 bit ignored", pdn_eff_o, 1'b0);
      pdn_pin = 1'b1;
      @(negedge clk);
      check("R5 one edge", pdn_eff_o, 1'b0);
      @(negedge clk);
      check("R5 two edges", pdn_eff_o, 1'b1);
      check("R6 pad/clk", {pad_dis_o, clk_en_o}, 2'b10);
      pdn_pin = 1'b0;
      @(negedge clk);
      check("R5 fall one edge", pdn_eff_o, 1'b1);
      @(negedge clk);
      check("R5 fall two edges", pdn_eff_o, 1'b0);

      // R8: pin reacquire edge
      reacq_pin = 1'b1;
      @(negedge clk);
      check("R8 one edge", reacq_pulse_o, 1'b0);
      @(negedge clk);
      check("R8 pulse", reacq_pulse_o, 1'b1);
      @(negedge clk);
      check("R8 single", reacq_pulse_o, 1'b0);
      repeat (3) @(negedge clk);
      check("R8 held pin", reacq_pulse_o, 1'b0);
      reacq_pin = 1'b0;
      repeat (3) @(negedge clk);

      // R11: hold without a write
      write_reg(8'h37);
      repeat (5) @(negedge clk);
      check("R11 hold", rd_data, 8'h37);

      // R9: soft reset, with a write discarded during the pulse
      write_reg(8'h8F);
      check("R9 pulse", soft_rst_o, 1'b1);
      check("R10 rst bit reads 0", rd_data, 8'h0F);
      wr_en = 1'b1;
      wr_data = 8'h05;
      @(negedge clk);
      wr_en = 1'b0;
      check("R9 single", soft_rst_o, 1'b0);
      check("R9 cleared", rd_data, 8'h00);
      check("R9 outs", {psave_mode_o, outs()}, 7'b0000001);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
   end

endmodule